// File: doc/BRIEF.md
# Byte Packing Data Buffer

This block sits between a 16-bit host data port and a byte-wide serial engine. One 32-bit store holds up to four bytes. On the transmit side the host loads halfwords, or a single trailing byte, and the engine pops the bytes out oldest first. On the receive side the engine deposits bytes one at a time, and the host drains them two per read. An endian input picks whether the two bytes of a halfword travel high-byte-first or low-byte-first, in both directions.

The block keeps separate transmit and receive byte counts over the shared store. It raises the ready, lone-byte, underflow and overflow flags that a surrounding controller turns into interrupts or DMA requests. A start strobe opens a new transfer with an empty store. At most one operation takes effect per clock, chosen by a fixed priority.

Top module: `byte_pack_buf`

## Requirements
- R1: A halfword host write (`hostWrEn` with `hostWrByte`=0) while `txCount` ≤ 2 shifts the store left by 16 bits, puts the new halfword in bits 15:0 and adds 2 to `txCount`. While `txCount` > 2 the write changes nothing, the flags included.
- R2: With `bigEndian`=1 a halfword write stores `hostWrData` unchanged, so `hostWrData[15:8]` is transmitted first. With `bigEndian`=0 the two bytes are exchanged before they are stored, so `hostWrData[7:0]` is transmitted first.
- R3: A byte host write (`hostWrByte`=1) while `txCount` ≤ 2 shifts the store left by 8 bits, puts `hostWrData[7:0]` in bits 7:0 and adds 1 to `txCount`. While `txCount` > 2 it is ignored.
- R4: While `txCount` > 0, `txByte` shows store bits [8·(txCount−1) +: 8], which is the oldest queued byte. A `txPop` lowers `txCount` by 1.
- R5: An `rxPush` with `rxCount` < 4 ORs `rxByte` into store bits [8·rxCount +: 8] and adds 1 to `rxCount`. With `rxCount` = 4 the byte is dropped and `overflow` is set.
- R6: `rdData` always shows the two lowest store bytes: {byte1, byte0} when `bigEndian`=0 and {byte0, byte1} when `bigEndian`=1.
- R7: A host read with `rxCount` = 1 sets `singleByte`, clears the whole store and sets `rxCount` to 0.
- R8: A host read with `rxCount` > 2 shifts the store right by 16 bits and lowers `rxCount` by 2. With `rxCount` = 2 it clears the store and sets `rxCount` to 0. With `rxCount` = 0 it leaves the store and the counts unchanged.
- R9: An accepted host write clears `underflow`. A `txPop` with `txCount` = 0 sets `underflow` and changes no count.
- R10: An accepted write that leaves `txCount` > 2 clears `txReady`. A pop that leaves `txCount` ≤ 2 sets `txReady`.
- R11: Every host read clears `overflow`. A read that leaves `rxCount` at 0 clears `rxReady`. An accepted push sets `rxReady`.
- R12: Reset clears the store, both counts and all flags. `xferStart` does the same but sets `txReady`.
- R13: When several strobes are high in the same cycle, only the highest one acts. The order is `xferStart`, then host write, then host read, then `txPop`, then `rxPush`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| xferStart | input | 1 | Open a new transfer and empty the store |
| bigEndian | input | 1 | Halfword byte order select |
| hostWrEn | input | 1 | Host write strobe |
| hostWrByte | input | 1 | Host write is a single byte |
| hostWrData | input | 16 | Host write data |
| hostRdEn | input | 1 | Host read strobe (pops the shown halfword) |
| rdData | output | 16 | Halfword offered to the host |
| txPop | input | 1 | Engine takes one transmit byte |
| txByte | output | 8 | Oldest queued transmit byte |
| rxPush | input | 1 | Engine delivers one received byte |
| rxByte | input | 8 | Received byte |
| txCount | output | 3 | Queued transmit bytes (0 to 4) |
| rxCount | output | 3 | Held receive bytes (0 to 4) |
| txReady | output | 1 | Transmit side can take more data |
| rxReady | output | 1 | Receive data is waiting |
| singleByte | output | 1 | Last read carried only one valid byte |
| underflow | output | 1 | Engine popped an empty transmit queue |
| overflow | output | 1 | Received byte dropped because the store was full |

## Verification
A wrong count shows up on the next clock in `txCount` or `rxCount`. It then shows again a few operations later as the wrong byte on `txByte` or a wrongly shifted `rdData`. A swap or shift error in the store appears as soon as the affected byte reaches the bottom of the store or the pop position. Because the same bytes pass through the host and engine views, long random mixes of writes, pops, pushes and reads expose misplaced bytes within a handful of cycles. The flags are compared on every clock, so a wrong set or clear is caught in the cycle after the strobe that caused it.

// File: rtl/byte_pack_buf_pkg.sv
package byte_pack_buf_pkg;
  localparam int BufBytes  = 4;
  localparam int HalfBytes = 2;
  localparam int ByteW     = 8;
  localparam int HalfW     = HalfBytes * ByteW;
  localparam int BufW      = BufBytes * ByteW;
  localparam int CntW      = $clog2(BufBytes + 1);
  localparam int IdxW      = $clog2(BufBytes);

  // strobes from control to the store
  typedef struct packed {
    logic            clear;
    logic            loadHalf;
    logic            loadByte;
    logic            dropTwo;
    logic            dropAll;
    logic            rxInsert;
    logic [IdxW-1:0] rxSlot;
  } bufStrobe_t;
endpackage

// File: rtl/byte_pack_buf_ctrl.sv
module byte_pack_buf_ctrl
  import byte_pack_buf_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            xferStart,
  input  logic            hostWrEn,
  input  logic            hostWrByte,
  input  logic            hostRdEn,
  input  logic            txPop,
  input  logic            rxPush,
  output bufStrobe_t      strobe,
  output logic [IdxW-1:0] txIdx,
  output logic [CntW-1:0] txCount,
  output logic [CntW-1:0] rxCount,
  output logic            txReady,
  output logic            rxReady,
  output logic            singleByte,
  output logic            underflow,
  output logic            overflow
);
  localparam logic [CntW-1:0] kFull = CntW'(BufBytes);
  localparam logic [CntW-1:0] kHalf = CntW'(HalfBytes);
  localparam logic [CntW-1:0] kRoom = CntW'(BufBytes - HalfBytes);
  localparam logic [CntW-1:0] kOne  = CntW'(1);

  logic doStart, doWr, doRd, doPop, doPush;
  logic wrOk;
  logic [CntW-1:0] wrStep, txNext, rxNext;

  // R13: fixed priority, one operation per clock
  always_comb begin
    doStart = xferStart;
    doWr    = !xferStart && hostWrEn;
    doRd    = !xferStart && !hostWrEn && hostRdEn;
    doPop   = !xferStart && !hostWrEn && !hostRdEn && txPop;
    doPush  = !xferStart && !hostWrEn && !hostRdEn && !txPop && rxPush;
    wrOk    = (txCount <= kRoom);
    wrStep  = hostWrByte ? kOne : kHalf;
  end

  always_comb begin
    strobe          = '0;
    strobe.clear    = doStart;
    strobe.loadHalf = doWr && wrOk && !hostWrByte;
    strobe.loadByte = doWr && wrOk && hostWrByte;
    strobe.dropTwo  = doRd && (rxCount > kHalf);
    strobe.dropAll  = doRd && (rxCount == kOne || rxCount == kHalf);
    strobe.rxInsert = doPush && (rxCount < kFull);
    strobe.rxSlot   = rxCount[IdxW-1:0];
  end

  always_comb begin
    txNext = txCount;
    if (doWr && wrOk)                   txNext = txCount + wrStep;
    else if (doPop && txCount != '0)    txNext = txCount - kOne;
    rxNext = rxCount;
    if (strobe.dropTwo)                 rxNext = rxCount - kHalf;
    else if (strobe.dropAll)            rxNext = '0;
    else if (strobe.rxInsert)           rxNext = rxCount + kOne;
  end

  assign txIdx = (txCount == '0) ? '0 : IdxW'(txCount - kOne);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCount    <= '0;
      rxCount    <= '0;
      txReady    <= 1'b0;
      rxReady    <= 1'b0;
      singleByte <= 1'b0;
      underflow  <= 1'b0;
      overflow   <= 1'b0;
    end else if (doStart) begin
      txCount    <= '0;
      rxCount    <= '0;
      txReady    <= 1'b1;
      rxReady    <= 1'b0;
      singleByte <= 1'b0;
      underflow  <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      txCount <= txNext;
      rxCount <= rxNext;
      if (doWr && wrOk) begin
        underflow <= 1'b0;
        if (txNext > kRoom) txReady <= 1'b0;
      end
      if (doRd) begin
        overflow <= 1'b0;
        if (rxCount == kOne) singleByte <= 1'b1;
        if (rxNext == '0) rxReady <= 1'b0;
      end
      if (doPop) begin
        if (txCount == '0) underflow <= 1'b1;
        else if (txNext <= kRoom) txReady <= 1'b1;
      end
      if (doPush) begin
        if (rxCount == kFull) overflow <= 1'b1;
        else rxReady <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/byte_pack_buf_dpath.sv
module byte_pack_buf_dpath
  import byte_pack_buf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  bufStrobe_t       strobe,
  input  logic             bigEndian,
  input  logic [HalfW-1:0] hostWrData,
  input  logic [ByteW-1:0] rxByte,
  input  logic [IdxW-1:0]  txIdx,
  output logic [HalfW-1:0] rdData,
  output logic [ByteW-1:0] txByte
);
  logic [BufW-1:0]  store;
  logic [HalfW-1:0] halfIn;
  logic [ByteW-1:0] lanes [BufBytes];

  for (genvar g = 0; g < BufBytes; g++) begin : g_lane
    assign lanes[g] = store[g*ByteW +: ByteW];
  end

  assign halfIn = bigEndian ? hostWrData
                            : {hostWrData[ByteW-1:0], hostWrData[HalfW-1:ByteW]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                store <= '0;
    else if (strobe.clear)    store <= '0;
    else if (strobe.loadHalf) store <= {store[BufW-HalfW-1:0], halfIn};
    else if (strobe.loadByte) store <= {store[BufW-ByteW-1:0], hostWrData[ByteW-1:0]};
    else if (strobe.dropTwo)  store <= store >> HalfW;
    else if (strobe.dropAll)  store <= '0;
    else if (strobe.rxInsert) store <= store | (BufW'(rxByte) << {strobe.rxSlot, 3'b000});
  end

  assign rdData = bigEndian ? {lanes[0], lanes[1]} : {lanes[1], lanes[0]};
  assign txByte = lanes[txIdx];
endmodule

// File: rtl/byte_pack_buf.sv
module byte_pack_buf
  import byte_pack_buf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        xferStart,
  input  logic        bigEndian,
  input  logic        hostWrEn,
  input  logic        hostWrByte,
  input  logic [15:0] hostWrData,
  input  logic        hostRdEn,
  output logic [15:0] rdData,
  input  logic        txPop,
  output logic [7:0]  txByte,
  input  logic        rxPush,
  input  logic [7:0]  rxByte,
  output logic [2:0]  txCount,
  output logic [2:0]  rxCount,
  output logic        txReady,
  output logic        rxReady,
  output logic        singleByte,
  output logic        underflow,
  output logic        overflow
);
  bufStrobe_t      strobe;
  logic [IdxW-1:0] txIdx;

  byte_pack_buf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .xferStart(xferStart), .hostWrEn(hostWrEn),
    .hostWrByte(hostWrByte), .hostRdEn(hostRdEn), .txPop(txPop), .rxPush(rxPush),
    .strobe(strobe), .txIdx(txIdx), .txCount(txCount), .rxCount(rxCount),
    .txReady(txReady), .rxReady(rxReady), .singleByte(singleByte),
    .underflow(underflow), .overflow(overflow)
  );

  byte_pack_buf_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bigEndian(bigEndian),
    .hostWrData(hostWrData), .rxByte(rxByte), .txIdx(txIdx),
    .rdData(rdData), .txByte(txByte)
  );
endmodule

// File: rtl/byte_pack_buf_chk.sv
module byte_pack_buf_chk (
  input logic        clk,
  input logic        rstN,
  input logic        xferStart,
  input logic        hostWrEn,
  input logic        hostWrByte,
  input logic        hostRdEn,
  input logic        txPop,
  input logic        rxPush,
  input logic [2:0]  txCount,
  input logic [2:0]  rxCount,
  input logic        txReady,
  input logic        rxReady,
  input logic        singleByte,
  input logic        underflow,
  input logic        overflow
);
  a_r1_tx_bound: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= 3'd4);

  a_r1_full_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!xferStart && hostWrEn && txCount > 3'd2) |=> $stable(txCount) && $stable(underflow));

  a_r5_rx_bound: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= 3'd4);

  a_r5_overflow_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (!xferStart && !hostWrEn && !hostRdEn && !txPop && rxPush && rxCount == 3'd4)
      |=> overflow && rxCount == 3'd4);

  a_r7_single_byte_read: assert property (@(posedge clk) disable iff (!rstN)
    (!xferStart && !hostWrEn && hostRdEn && rxCount == 3'd1)
      |=> singleByte && rxCount == 3'd0 && !rxReady);

  a_r9_write_clears_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (!xferStart && hostWrEn && txCount <= 3'd2) |=> !underflow);

  a_r11_read_clears_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (!xferStart && !hostWrEn && hostRdEn) |=> !overflow);

  a_r12_start_empties: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> txCount == 3'd0 && rxCount == 3'd0 && txReady && !singleByte);
endmodule

bind byte_pack_buf byte_pack_buf_chk u_chk (.*);

// File: tb/byte_pack_buf_tb.sv
module byte_pack_buf_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xferStart = 0, bigEndian = 0, hostWrEn = 0, hostWrByte = 0;
  logic [15:0] hostWrData = '0;
  logic        hostRdEn = 0, txPop = 0, rxPush = 0;
  logic [7:0]  rxByte = '0;
  logic [15:0] rdData;
  logic [7:0]  txByte;
  logic [2:0]  txCount, rxCount;
  logic        txReady, rxReady, singleByte, underflow, overflow;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] mBuf;
  int mTx, mRx;
  bit mTxR, mRxR, mSb, mUdf, mOvf;

  always #2 clk = ~clk;

  byte_pack_buf u_dut (.*);

  function automatic logic [15:0] expRd(logic [31:0] b, bit be);
    return be ? {b[7:0], b[15:8]} : b[15:0];
  endfunction

  function automatic logic [7:0] expTx(logic [31:0] b, int n);
    return (n == 0) ? 8'h00 : b[8*(n-1) +: 8];
  endfunction

  task automatic modelReset(bit startVal);
    mBuf = '0; mTx = 0; mRx = 0;
    mTxR = startVal; mRxR = 0; mSb = 0; mUdf = 0; mOvf = 0;
  endtask

  task automatic modelStep(bit st, bit wr, bit wb, bit rd, bit pop, bit push,
                           bit be, logic [15:0] d, logic [7:0] rb);
    if (st) modelReset(1);
    else if (wr) begin
      if (mTx <= 2) begin
        if (wb) begin mBuf = {mBuf[23:0], d[7:0]}; mTx += 1; end
        else begin mBuf = {mBuf[15:0], (be ? d : {d[7:0], d[15:8]})}; mTx += 2; end
        mUdf = 0;
        if (mTx > 2) mTxR = 0;
      end
    end else if (rd) begin
      mOvf = 0;
      if (mRx == 1) begin mSb = 1; mRx = 0; mBuf = '0; end
      else if (mRx == 2) begin mRx = 0; mBuf = '0; end
      else if (mRx > 2) begin mBuf = mBuf >> 16; mRx -= 2; end
      if (mRx == 0) mRxR = 0;
    end else if (pop) begin
      if (mTx == 0) mUdf = 1;
      else begin mTx -= 1; if (mTx <= 2) mTxR = 1; end
    end else if (push) begin
      if (mRx == 4) mOvf = 1;
      else begin mBuf = mBuf | (32'(rb) << (8 * mRx)); mRx += 1; mRxR = 1; end
    end
  endtask

  task automatic checkAll(string tag);
    logic [39:0] act, exp;
    act = {rdData, (txCount != 0) ? txByte : 8'h00, 1'b0, txCount, 1'b0, rxCount,
           3'b0, txReady, rxReady, singleByte, underflow, overflow};
    exp = {expRd(mBuf, bigEndian), expTx(mBuf, mTx), 1'b0, 3'(mTx), 1'b0, 3'(mRx),
           3'b0, mTxR, mRxR, mSb, mUdf, mOvf};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (rd,tx,txc,rxc,flags)", tag, act, exp);
    end
  endtask

  // one clock of stimulus, then compare at the following falling edge
  task automatic step(bit st, bit wr, bit wb, bit rd, bit pop, bit push, bit be,
                      logic [15:0] d, logic [7:0] rb, string tag);
    xferStart = st; hostWrEn = wr; hostWrByte = wb; hostRdEn = rd;
    txPop = pop; rxPush = push; bigEndian = be; hostWrData = d; rxByte = rb;
    modelStep(st, wr, wb, rd, pop, push, be, d, rb);
    @(negedge clk);
    xferStart = 0; hostWrEn = 0; hostRdEn = 0; txPop = 0; rxPush = 0;
    checkAll(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0b1f));
    modelReset(0);
    repeat (3) @(negedge clk);
    checkAll("R12 reset");
    rstN = 1;
    @(negedge clk);
    step(1,0,0,0,0,0,0,16'h0,8'h0,"R12 start");
    // little-endian halfword then byte, popped oldest first
    step(0,1,0,0,0,0,0,16'hA1B2,8'h0,"R1 R2 R9 half LE");
    step(0,1,1,0,0,0,0,16'h00C3,8'h0,"R3 R10 byte");
    step(0,1,0,0,0,0,0,16'hFFFF,8'h0,"R1 ignored when full");
    step(0,1,1,0,0,0,0,16'h00EE,8'h0,"R3 ignored when full");
    step(0,0,0,0,1,0,0,16'h0,8'h0,"R4 R10 pop");
    step(0,0,0,0,1,0,0,16'h0,8'h0,"R4 pop");
    step(0,0,0,0,1,0,0,16'h0,8'h0,"R4 pop");
    step(0,0,0,0,1,0,0,16'h0,8'h0,"R9 underflow");
    step(0,1,0,0,0,0,1,16'h1234,8'h0,"R2 R9 half BE");
    step(0,1,0,0,0,0,1,16'h5678,8'h0,"R1 R10 second half");
    step(1,0,0,0,0,0,0,16'h0,8'h0,"R12 start");
    // receive path: fill, overflow, drain
    for (int i = 0; i < 5; i++) step(0,0,0,0,0,1,0,16'h0,8'(8'h10 + i),"R5 R11 push");
    step(0,0,0,1,0,0,0,16'h0,8'h0,"R6 R8 R11 read");
    step(0,0,0,1,0,0,1,16'h0,8'h0,"R6 R8 read BE");
    step(0,0,0,1,0,0,0,16'h0,8'h0,"R8 read empty");
    step(0,0,0,0,0,1,0,16'h0,8'h77,"R5 push");
    step(0,0,0,1,0,0,0,16'h0,8'h0,"R7 single byte");
    step(0,1,1,1,1,1,0,16'h0042,8'h99,"R13 write wins");
    step(0,0,0,1,1,1,0,16'h0,8'h99,"R13 read wins");
    step(0,0,0,0,1,1,0,16'h0,8'h99,"R13 pop wins");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      bit st, wr, wb, rd, pop, push;
      r = $urandom_range(0, 99);
      st = (r < 3); wr = (r >= 3 && r < 30); rd = (r >= 30 && r < 50);
      pop = (r >= 50 && r < 75); push = (r >= 75);
      if ($urandom_range(0, 9) == 0) begin rd = 1; pop = 1; end
      wb = ($urandom_range(0, 3) == 0);
      step(st, wr, wb, rd, pop, push, 1'($urandom_range(0, 1)),
           16'($urandom), 8'($urandom), "R1 R4 R5 R6 R8 R13 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule